// File: doc/BRIEF.md
# Display Processor Bus Decoder

This block sits between a 16-bit, 68000-style processor and the memories and peripherals of a dot-matrix display controller. From the two top address bits it chooses a bus region: program ROM, work RAM, an empty hole, or a peripheral group. Inside the peripheral group it raises a select for a CRT controller or for a board I/O port. The I/O port carries the host command latch, which the processor reads, and the status byte, which the processor writes. Every signal that decodes or steers data is combinational.

The block also picks how each cycle ends. ROM, RAM and hole cycles end with the asynchronous acknowledge (DTACK). Peripheral cycles end with the synchronous valid-peripheral request (VPA), and peripheral selects only open once the processor returns valid-memory-address (VMA). RAM data and byte enables cross the bus with their lanes swapped, so the byte order in storage is the reverse of the byte order the processor sees.

The one register in the block is a level-2 interrupt flag. A vertical-blank input sets it. Any access to the CRT controller clears it.

Top module: `dispbus_decode`

## Requirements
- R1: With `asValid` high, byte-address bits 23:22 select the region (00 ROM, 01 hole, 10 RAM, 11 peripheral). `vpa` is high for the peripheral region only, and `dtack` is high for the other three. Both are low while `asValid` is low.
- R2: In a peripheral cycle with `vma` high, address bit 4 set raises `crtcSel`. Otherwise bit 5 set selects the I/O port. Bit 4 has priority over bit 5. With `vma` low, no peripheral select rises and `cpuRdata` is zero.
- R3: A CRT read with address bit 1 clear (the address register, 0xC00010) returns zero on `cpuRdata`.
- R4: A CRT read with address bit 1 set (the data register, 0xC00012) returns `crtcRdata` on bits 15:8 and zero on bits 7:0 when `upperStb` is high. When `upperStb` is low it returns all zero. `crtcRegSel` follows address bit 1.
- R5: A CRT write with `upperStb` high raises `crtcWr` and drives `cpuWdata[15:8]` on `crtcWdata`. A CRT write with `upperStb` low does not raise `crtcWr`.
- R6: Out of reset `irq2` is low. A cycle with `vblank` high and no CRT access makes `irq2` high on the next clock. A cycle with neither event leaves `irq2` unchanged.
- R7: Any cycle with `crtcSel` high makes `irq2` low on the next clock, whether it is a read or a write. This takes priority over a `vblank` in the same cycle.
- R8: In a RAM write, `ramWdata` is {`cpuWdata[7:0]`, `cpuWdata[15:8]`} and `ramWe` is {`lowerStb`, `upperStb`}. A RAM read returns {`ramRdata[7:0]`, `ramRdata[15:8]`}. `ramSel` is high for RAM cycles only.
- R9: `romSel` is high only for ROM reads, and a ROM read returns `romRdata`. A ROM write and any hole access raise no select, still end with `dtack`, and return zero.
- R10: An I/O read raises `latchRd` and returns {8'h00, `cmdLatch`}. An I/O write with `lowerStb` high raises `statusWr` and drives all of `cpuWdata[7:0]` on `statusData`.
- R11: Every read data path returns zero during a write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| asValid | input | 1 | Address strobe, bus cycle in progress |
| rdWr | input | 1 | 1 = read, 0 = write |
| upperStb | input | 1 | Upper byte lane (15:8) strobe |
| lowerStb | input | 1 | Lower byte lane (7:0) strobe |
| vma | input | 1 | Valid memory address for a synchronous peripheral cycle |
| cpuAddr | input | 23 | Byte address bits 23:1 |
| cpuWdata | input | 16 | Processor write data |
| cpuRdata | output | 16 | Read data returned to the processor |
| dtack | output | 1 | Asynchronous cycle acknowledge |
| vpa | output | 1 | Synchronous peripheral cycle request |
| romSel | output | 1 | ROM read select |
| romRdata | input | 16 | ROM data |
| ramSel | output | 1 | RAM select |
| ramWe | output | 2 | RAM lane write enables, storage order |
| ramWdata | output | 16 | RAM write data, lanes swapped |
| ramRdata | input | 16 | RAM data in storage order |
| crtcSel | output | 1 | CRT controller select |
| crtcRegSel | output | 1 | 0 = address register, 1 = data register |
| crtcWr | output | 1 | CRT controller write strobe |
| crtcWdata | output | 8 | CRT controller write byte |
| crtcRdata | input | 8 | CRT controller read byte |
| cmdLatch | input | 8 | Host command latch contents |
| latchRd | output | 1 | Command latch read strobe |
| statusWr | output | 1 | Status byte write strobe |
| statusData | output | 8 | Status byte |
| vblank | input | 1 | Vertical blank event |
| irq2 | output | 1 | Level-2 interrupt request |

## Verification
Every select, strobe, handshake and read data result depends only on the current inputs, so it is due in the same cycle the stimulus is applied. The bench applies each stimulus just after a rising edge and compares the outputs at the following falling edge. `irq2` is the one registered result. It reflects the `vblank` and CRT events of a cycle one rising edge later. The bench reference model updates its own flag at that rising edge, so the comparison at the next falling edge checks the new value.

// File: rtl/dbus_pkg.sv
package dbus_pkg;
  typedef enum logic [1:0] {
    RG_ROM  = 2'b00,
    RG_GAP  = 2'b01,
    RG_RAM  = 2'b10,
    RG_PERI = 2'b11
  } regionT;

  typedef struct packed {
    logic useDtack;
    logic useVpa;
    logic rd;
    logic romRd;
    logic ramAcc;
    logic crtcAcc;
    logic crtcData;
    logic ioAcc;
  } strobeT;
endpackage

// File: rtl/dbus_ctrl.sv
module dbus_ctrl
  import dbus_pkg::*;
#(
  parameter int ADDR_HI  = 23,
  parameter int CRTC_BIT = 4,
  parameter int IO_BIT   = 5,
  parameter int REG_BIT  = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             asValid,
  input  logic             rdWr,
  input  logic             vma,
  input  logic [ADDR_HI:1] cpuAddr,
  input  logic             vblank,
  output strobeT           stb,
  output logic             irq2
);
  localparam int REG_LO = ADDR_HI - 1;

  regionT region;
  assign region = regionT'(cpuAddr[ADDR_HI:REG_LO]);

  always_comb begin
    stb = '0;
    stb.rd = rdWr;
    stb.crtcData = cpuAddr[REG_BIT];
    if (asValid) begin
      unique case (region)
        RG_ROM: begin
          stb.useDtack = 1'b1;
          stb.romRd = rdWr;
        end
        RG_GAP: stb.useDtack = 1'b1;
        RG_RAM: begin
          stb.useDtack = 1'b1;
          stb.ramAcc = 1'b1;
        end
        RG_PERI: begin
          stb.useVpa = 1'b1;
          if (vma) begin
            if (cpuAddr[CRTC_BIT]) stb.crtcAcc = 1'b1;
            else if (cpuAddr[IO_BIT]) stb.ioAcc = 1'b1;
          end
        end
        default: stb.useDtack = 1'b1;
      endcase
    end
  end

  // interrupt flag: CRT access clears, taking priority over a new vblank
  always_ff @(posedge clk) begin
    if (!rstN) irq2 <= 1'b0;
    else if (stb.crtcAcc) irq2 <= 1'b0;
    else if (vblank) irq2 <= 1'b1;
  end
endmodule

// File: rtl/dbus_datapath.sv
module dbus_datapath
  import dbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  strobeT              stb,
  input  logic                upperStb,
  input  logic                lowerStb,
  input  logic [DATA_W-1:0]   cpuWdata,
  output logic [DATA_W-1:0]   cpuRdata,
  output logic                romSel,
  input  logic [DATA_W-1:0]   romRdata,
  output logic                ramSel,
  output logic [1:0]          ramWe,
  output logic [DATA_W-1:0]   ramWdata,
  input  logic [DATA_W-1:0]   ramRdata,
  output logic                crtcSel,
  output logic                crtcRegSel,
  output logic                crtcWr,
  output logic [DATA_W/2-1:0] crtcWdata,
  input  logic [DATA_W/2-1:0] crtcRdata,
  input  logic [DATA_W/2-1:0] cmdLatch,
  output logic                latchRd,
  output logic                statusWr,
  output logic [DATA_W/2-1:0] statusData
);
  localparam int BYTE_W = DATA_W / 2;

  logic [BYTE_W-1:0] wrHi, wrLo;
  assign wrHi = cpuWdata[DATA_W-1:BYTE_W];
  assign wrLo = cpuWdata[BYTE_W-1:0];

  assign romSel     = stb.romRd;
  assign ramSel     = stb.ramAcc;
  assign ramWe      = (stb.ramAcc && !stb.rd) ? {lowerStb, upperStb} : 2'b00;
  assign ramWdata   = {wrLo, wrHi};
  assign crtcSel    = stb.crtcAcc;
  assign crtcRegSel = stb.crtcData;
  assign crtcWr     = stb.crtcAcc && !stb.rd && upperStb;
  assign crtcWdata  = wrHi;
  assign latchRd    = stb.ioAcc && stb.rd;
  assign statusWr   = stb.ioAcc && !stb.rd && lowerStb;
  assign statusData = wrLo;

  always_comb begin
    cpuRdata = '0;
    if (stb.rd) begin
      if (stb.romRd) cpuRdata = romRdata;
      else if (stb.ramAcc) cpuRdata = {ramRdata[BYTE_W-1:0], ramRdata[DATA_W-1:BYTE_W]};
      else if (stb.crtcAcc && stb.crtcData && upperStb) cpuRdata = {crtcRdata, {BYTE_W{1'b0}}};
      else if (stb.ioAcc) cpuRdata = {{BYTE_W{1'b0}}, cmdLatch};
    end
  end
endmodule

// File: rtl/dispbus_decode.sv
module dispbus_decode
  import dbus_pkg::*;
#(
  parameter int ADDR_HI = 23,
  parameter int DATA_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                asValid,
  input  logic                rdWr,
  input  logic                upperStb,
  input  logic                lowerStb,
  input  logic                vma,
  input  logic [ADDR_HI:1]    cpuAddr,
  input  logic [DATA_W-1:0]   cpuWdata,
  output logic [DATA_W-1:0]   cpuRdata,
  output logic                dtack,
  output logic                vpa,
  output logic                romSel,
  input  logic [DATA_W-1:0]   romRdata,
  output logic                ramSel,
  output logic [1:0]          ramWe,
  output logic [DATA_W-1:0]   ramWdata,
  input  logic [DATA_W-1:0]   ramRdata,
  output logic                crtcSel,
  output logic                crtcRegSel,
  output logic                crtcWr,
  output logic [DATA_W/2-1:0] crtcWdata,
  input  logic [DATA_W/2-1:0] crtcRdata,
  input  logic [DATA_W/2-1:0] cmdLatch,
  output logic                latchRd,
  output logic                statusWr,
  output logic [DATA_W/2-1:0] statusData,
  input  logic                vblank,
  output logic                irq2
);
  strobeT stb;

  dbus_ctrl #(.ADDR_HI(ADDR_HI)) u_ctrl (
    .clk(clk), .rstN(rstN), .asValid(asValid), .rdWr(rdWr), .vma(vma),
    .cpuAddr(cpuAddr), .vblank(vblank), .stb(stb), .irq2(irq2)
  );

  dbus_datapath #(.DATA_W(DATA_W)) u_dp (
    .stb(stb), .upperStb(upperStb), .lowerStb(lowerStb), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .romSel(romSel), .romRdata(romRdata), .ramSel(ramSel),
    .ramWe(ramWe), .ramWdata(ramWdata), .ramRdata(ramRdata), .crtcSel(crtcSel),
    .crtcRegSel(crtcRegSel), .crtcWr(crtcWr), .crtcWdata(crtcWdata),
    .crtcRdata(crtcRdata), .cmdLatch(cmdLatch), .latchRd(latchRd),
    .statusWr(statusWr), .statusData(statusData)
  );

  assign dtack = stb.useDtack;
  assign vpa   = stb.useVpa;
endmodule

// File: rtl/dbus_checker.sv
module dbus_checker #(
  parameter int ADDR_HI = 23,
  parameter int DATA_W  = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                asValid,
  input logic                rdWr,
  input logic                vma,
  input logic [DATA_W-1:0]   cpuWdata,
  input logic [DATA_W-1:0]   cpuRdata,
  input logic                dtack,
  input logic                vpa,
  input logic                romSel,
  input logic                ramSel,
  input logic [DATA_W-1:0]   ramWdata,
  input logic                crtcSel,
  input logic                crtcRegSel,
  input logic                vblank,
  input logic                irq2
);
  localparam int BYTE_W = DATA_W / 2;

  p_one_handshake_r1: assert property (@(posedge clk) disable iff (!rstN) !(dtack && vpa));
  p_ack_when_busy_r1: assert property (@(posedge clk) disable iff (!rstN) asValid |-> (dtack || vpa));
  p_crtc_sync_r2: assert property (@(posedge clk) disable iff (!rstN) crtcSel |-> (vpa && vma));
  p_addr_read_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (crtcSel && !crtcRegSel && rdWr) |-> (cpuRdata == '0));
  p_irq_set_r6: assert property (@(posedge clk) disable iff (!rstN) (vblank && !crtcSel) |=> irq2);
  p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rstN) (!vblank && !crtcSel) |=> $stable(irq2));
  p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rstN) crtcSel |=> !irq2);
  p_ram_swap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ramSel && !rdWr) |-> (ramWdata == {cpuWdata[BYTE_W-1:0], cpuWdata[DATA_W-1:BYTE_W]}));
  p_rom_readonly_r9: assert property (@(posedge clk) disable iff (!rstN) romSel |-> (rdWr && dtack));
  p_write_no_data_r11: assert property (@(posedge clk) disable iff (!rstN) !rdWr |-> (cpuRdata == '0));
endmodule

bind dispbus_decode dbus_checker #(.ADDR_HI(ADDR_HI), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/dispbus_decode_bench.sv
`timescale 1ns/100ps
module dispbus_decode_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic asValid = 0, rdWr = 1, upperStb = 0, lowerStb = 0, vma = 0, vblank = 0;
  logic [23:0] addr = '0;
  logic [15:0] cpuWdata = '0, romRdata = 16'h1234, ramRdata = 16'h12C3;
  logic [7:0]  crtcRdata = 8'h5E, cmdLatch = 8'h9B;
  logic [15:0] cpuRdata, ramWdata;
  logic dtack, vpa, romSel, ramSel, crtcSel, crtcRegSel, crtcWr, latchRd, statusWr, irq2;
  logic [1:0] ramWe;
  logic [7:0] crtcWdata, statusData;
  int total = 0, bad = 0;
  logic irqModel = 1'b0;

  always #2 clk = ~clk;

  dispbus_decode u_dispbus_decode (
    .clk(clk), .rstN(rstN), .asValid(asValid), .rdWr(rdWr), .upperStb(upperStb),
    .lowerStb(lowerStb), .vma(vma), .cpuAddr(addr[23:1]), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .dtack(dtack), .vpa(vpa), .romSel(romSel), .romRdata(romRdata),
    .ramSel(ramSel), .ramWe(ramWe), .ramWdata(ramWdata), .ramRdata(ramRdata),
    .crtcSel(crtcSel), .crtcRegSel(crtcRegSel), .crtcWr(crtcWr), .crtcWdata(crtcWdata),
    .crtcRdata(crtcRdata), .cmdLatch(cmdLatch), .latchRd(latchRd), .statusWr(statusWr),
    .statusData(statusData), .vblank(vblank), .irq2(irq2)
  );

  // behavioural reference: region by address range
  function automatic bit isPeri(); return asValid && addr >= 24'hC00000; endfunction
  function automatic bit isCrtc(); return isPeri() && vma && addr[4]; endfunction

  always @(posedge clk) begin
    if (!rstN) irqModel <= 1'b0;
    else if (isCrtc()) irqModel <= 1'b0;
    else if (vblank) irqModel <= 1'b1;
  end

  function automatic logic [59:0] expected();
    logic [15:0] rd = 0; logic dt = 0, vp = 0, rs = 0, ms = 0, cs = 0, cw = 0, lr = 0, sw = 0;
    logic [1:0] we = 0;
    bit isIo;
    if (asValid) begin
      if (addr < 24'h400000) begin dt = 1; rs = rdWr; if (rdWr) rd = romRdata; end
      else if (addr < 24'h800000) dt = 1;
      else if (addr < 24'hC00000) begin
        dt = 1; ms = 1;
        if (rdWr) rd = {ramRdata[7:0], ramRdata[15:8]};
        else we = {lowerStb, upperStb};
      end else vp = 1;
    end
    isIo = isPeri() && vma && !addr[4] && addr[5];
    if (isCrtc()) begin
      cs = 1;
      if (rdWr && addr[1] && upperStb) rd = {crtcRdata, 8'h00};
      cw = !rdWr && upperStb;
    end
    if (isIo) begin
      lr = rdWr; sw = !rdWr && lowerStb;
      if (rdWr) rd = {8'h00, cmdLatch};
    end
    return {rd, dt, vp, rs, ms, we, {cpuWdata[7:0], cpuWdata[15:8]}, cs, addr[1], cw,
            cpuWdata[15:8], lr, sw, cpuWdata[7:0], irqModel};
  endfunction

  task automatic cyc(input logic a, input logic r, input logic u, input logic l, input logic v,
                     input logic [23:0] ad, input logic [15:0] wd, input logic vb, input string tag);
    logic [59:0] act, exp;
    asValid = a; rdWr = r; upperStb = u; lowerStb = l; vma = v; addr = ad; cpuWdata = wd; vblank = vb;
    @(negedge clk);
    exp = expected();
    act = {cpuRdata, dtack, vpa, romSel, ramSel, ramWe, ramWdata, crtcSel, crtcRegSel, crtcWr,
           crtcWdata, latchRd, statusWr, statusData, irq2};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, ad, act, exp);
    end
    @(posedge clk); #1;
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    vblank = 1;
    repeat (3) @(posedge clk);
    #1;
    cyc(0,1,0,0,0,24'h0,16'h0,1,"R6 reset irq low");
    rstN = 1;
    cyc(0,1,0,0,0,24'h0,16'h0,0,"R1 idle no handshake");
    cyc(1,1,1,1,0,24'h000100,16'h0,0,"R1 R9 rom read");
    cyc(1,1,1,1,0,24'h0FFFFE,16'h0,0,"R9 rom top read");
    cyc(1,0,1,1,0,24'h000200,16'hBEEF,0,"R9 rom write ignored");
    cyc(1,1,1,1,0,24'h400000,16'h0,0,"R9 hole read");
    cyc(1,0,1,1,0,24'h500010,16'h1111,0,"R9 hole write");
    cyc(1,1,1,1,0,24'h800000,16'h0,0,"R8 ram read page0");
    ramRdata = 16'hF00D;
    cyc(1,1,1,1,0,24'h801000,16'h0,0,"R8 ram read page1");
    cyc(1,0,1,0,0,24'h800002,16'hA1B2,0,"R8 ram upper write");
    cyc(1,0,0,1,0,24'h80FFFE,16'hC3D4,0,"R8 ram lower write");
    cyc(1,0,1,1,0,24'h800004,16'h0102,0,"R11 ram write no rdata");
    cyc(1,1,1,1,0,24'hC00012,16'h0,1,"R2 peri without vma");
    cyc(1,1,1,1,0,24'hC00012,16'h0,0,"R6 irq set after vblank");
    cyc(1,1,1,1,0,24'hC00000,16'h0,0,"R6 irq hold");
    cyc(1,1,1,0,1,24'hC00010,16'h0,0,"R3 crtc addr read zero");
    cyc(1,1,1,0,1,24'hC00010,16'h0,0,"R7 irq cleared by read");
    cyc(1,1,1,0,1,24'hC00012,16'h0,1,"R4 crtc data read upper");
    cyc(1,1,0,1,1,24'hC00012,16'h0,0,"R7 clear beats vblank");
    cyc(1,1,0,1,1,24'hC00012,16'h0,1,"R4 crtc data read no upper");
    cyc(1,0,1,0,1,24'hC00010,16'h3A00,1,"R5 crtc addr write");
    cyc(1,0,0,1,1,24'hC00012,16'h7700,0,"R5 crtc write no upper");
    cyc(1,0,1,1,1,24'hC00012,16'h4C99,1,"R5 R7 crtc data write");
    cyc(1,1,1,1,1,24'hC00030,16'h0,0,"R2 crtc priority over io");
    cyc(1,1,1,1,1,24'hC00020,16'h0,1,"R10 latch read");
    cyc(1,0,0,1,1,24'hC00020,16'h00E7,0,"R10 status write");
    cyc(1,0,1,0,1,24'hC00020,16'h00E7,0,"R10 status no lower");
    cyc(1,1,1,1,1,24'hC00000,16'h0,0,"R2 peri no select");
    cyc(1,1,1,1,1,24'hC00010,16'h0,0,"R7 irq low after access");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule